// File: doc/BRIEF.md
# 4x4 Block SAD Pipeline

This unit measures how closely a 4x4 reference candidate matches a 4x4 block of the picture being coded. It forms the sum of absolute differences between the two blocks. It is one slice of a block-matching search. A search controller keeps the current block on one bus and presents a new candidate block on the other bus in every clock cycle. The unit returns one sum per cycle once its pipeline is full.

Sixteen lanes each take the absolute difference of one pixel pair. Each lane subtracts the current pixel from the reference pixel, so the operand that gets negated is the one that seldom changes. The lane results are registered. A chain of row stages then builds the sum: each stage adds its own four lane values to the partial sum passed on from the row above it. An output register captures the total. A valid flag travels through the same two registers as the data.

Top module: `sad4x4_unit`

## Requirements
- R1: When `out_valid` is high, `sad_out` equals the sum over all sixteen pixel positions of |ref − cur|, with each pixel an unsigned 8-bit value. The sum is a 12-bit value, and its largest possible value is 4080.
- R2: `out_valid` rises exactly two clock edges after the edge that sampled `in_valid` high. A single-cycle input pulse gives a single-cycle output pulse.
- R3: Inputs presented with `in_valid` high on consecutive cycles give results on consecutive cycles, with no gaps, in the same order as the inputs.
- R4: A synchronous active-high `rst` forces `out_valid` and `sad_out` to 0 at the next edge, even while traffic is flowing.
- R5: While no valid data reaches the output stage, `sad_out` keeps its last value, whatever is applied to the pixel buses.
- R6: Corner cases: identical blocks give 0. A reference of all 255 against a current block of all 0 gives 4080, and so does the reverse. Swapping the reference and current blocks gives the same result.
- R7: Pixel i, with i = row*4 + col, sits at bits [8i+7:8i] of each bus. Pixel i of `cur_pix` is compared only with pixel i of `ref_pix`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel buses carry a candidate this cycle |
| cur_pix | input | 128 | Current block, 16 unsigned 8-bit pixels |
| ref_pix | input | 128 | Reference candidate, 16 unsigned 8-bit pixels |
| out_valid | output | 1 | `sad_out` holds a new result |
| sad_out | output | 12 | Sum of absolute differences |

## Verification
A new candidate can enter the difference lanes in the same cycle that the previous candidate's sum is being captured at the output. This can also happen while a reset is asserted. Overlap of this kind is provoked by streaming a table of vectors back to back with `in_valid` held high. Each result must match a behavioural sum for the input it belongs to, and must appear exactly two edges after that input. A reset applied in the middle of the stream must clear both outputs at once. An idle stretch in which the pixel buses change while `in_valid` stays low must leave `sad_out` frozen.

// File: rtl/sad4x4_pkg.sv
package sad4x4_pkg;

    // default geometry of the unit
    localparam int PIX_BITS  = 8;
    localparam int BLOCK_DIM = 4;

    // width needed to hold the sum of n terms of w bits each
    function automatic int sum_width(input int w, input int n);
        return w + $clog2(n);
    endfunction

    // position of the pipeline stage that a result currently occupies
    typedef enum logic [1:0] {
        STG_DIFF = 2'd0,
        STG_SUM  = 2'd1
    } stage_e;

endpackage

// File: rtl/sad_absdiff_lane.sv
module sad_absdiff_lane #(
    parameter int PIX_W = sad4x4_pkg::PIX_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PIX_W-1:0] ref_px,
    input  logic [PIX_W-1:0] cur_px,
    output logic [PIX_W-1:0] mag_q
);

    logic signed [PIX_W:0] delta;
    logic signed [PIX_W:0] mag;

    // reference minus current: the negated operand is the steady one
    always_comb begin
        delta = $signed({1'b0, ref_px}) - $signed({1'b0, cur_px});
        mag   = delta[PIX_W] ? -delta : delta;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mag_q <= '0;
        else if (en)
            mag_q <= mag[PIX_W-1:0];
    end

    AST_EQUAL_PIXELS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en && ref_px == cur_px) |=> (mag_q == '0)); // R6

endmodule

// File: rtl/sad_row_stage.sv
module sad_row_stage #(
    parameter int PIX_W   = sad4x4_pkg::PIX_BITS,
    parameter int ROW_LEN = sad4x4_pkg::BLOCK_DIM,
    parameter int SAD_W   = sad4x4_pkg::sum_width(PIX_W, ROW_LEN * ROW_LEN)
) (
    input  logic [SAD_W-1:0]         psad_in,
    input  logic [ROW_LEN*PIX_W-1:0] row_mags,
    output logic [SAD_W-1:0]         psad_out
);

    // partial sum from the row above plus this row's lanes
    always_comb begin
        psad_out = psad_in;
        for (int c = 0; c < ROW_LEN; c++)
            psad_out = psad_out + SAD_W'(row_mags[c*PIX_W +: PIX_W]);
    end

endmodule

// File: rtl/sad4x4_unit.sv
module sad4x4_unit #(
    parameter int PIX_W   = sad4x4_pkg::PIX_BITS,
    parameter int BLK_DIM = sad4x4_pkg::BLOCK_DIM,
    parameter int SAD_W   = sad4x4_pkg::sum_width(PIX_W, BLK_DIM * BLK_DIM)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic [BLK_DIM*BLK_DIM*PIX_W-1:0] cur_pix,
    input  logic [BLK_DIM*BLK_DIM*PIX_W-1:0] ref_pix,
    output logic                             out_valid,
    output logic [SAD_W-1:0]                 sad_out
);
    import sad4x4_pkg::*;

    localparam int NPIX    = BLK_DIM * BLK_DIM;
    localparam int ROW_W   = BLK_DIM * PIX_W;
    localparam int SAD_MAX = NPIX * ((1 << PIX_W) - 1);

    logic [NPIX*PIX_W-1:0] mags;
    logic [SAD_W-1:0]      psad [0:BLK_DIM];
    logic [1:0]            vld_pipe;   // indexed by stage_e

    // stage 0: sixteen difference lanes
    generate
        for (genvar i = 0; i < NPIX; i++) begin : g_lane
            sad_absdiff_lane #(.PIX_W(PIX_W)) u_lane (
                .clk    (clk),
                .rst    (rst),
                .en     (in_valid),
                .ref_px (ref_pix[i*PIX_W +: PIX_W]),
                .cur_px (cur_pix[i*PIX_W +: PIX_W]),
                .mag_q  (mags[i*PIX_W +: PIX_W])
            );
        end
    endgenerate

    // row chain: each row hands its partial sum to the next
    assign psad[0] = '0;
    generate
        for (genvar r = 0; r < BLK_DIM; r++) begin : g_row
            sad_row_stage #(
                .PIX_W   (PIX_W),
                .ROW_LEN (BLK_DIM),
                .SAD_W   (SAD_W)
            ) u_row (
                .psad_in  (psad[r]),
                .row_mags (mags[r*ROW_W +: ROW_W]),
                .psad_out (psad[r+1])
            );
        end
    endgenerate

    // valid tracking and output register
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_pipe <= '0;
            sad_out  <= '0;
        end else begin
            vld_pipe[STG_DIFF] <= in_valid;
            vld_pipe[STG_SUM]  <= vld_pipe[STG_DIFF];
            if (vld_pipe[STG_DIFF])
                sad_out <= psad[BLK_DIM];
        end
    end

    assign out_valid = vld_pipe[STG_SUM];

    AST_DIFF_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> vld_pipe[STG_DIFF]); // R2

    AST_OUT_FOLLOWS_DIFF: assert property (@(posedge clk) disable iff (rst)
        !vld_pipe[STG_DIFF] |=> !out_valid); // R2

    AST_SAD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sad_out <= SAD_W'(SAD_MAX))); // R1

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !vld_pipe[STG_DIFF] |=> $stable(sad_out)); // R5

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vld_pipe[STG_DIFF]) |=> (vld_pipe[STG_DIFF] && out_valid)); // R3

endmodule

// File: tb/sim_sad4x4_unit.sv
module sim_sad4x4_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] cur_pix;
    logic [127:0] ref_pix;
    logic         out_valid;
    logic [11:0]  sad_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sad4x4_unit u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .cur_pix   (cur_pix),
        .ref_pix   (ref_pix),
        .out_valid (out_valid),
        .sad_out   (sad_out)
    );

    typedef struct packed {
        logic [7:0]  c;
        logic [7:0]  r;
        logic [11:0] e;
    } vec_t;

    // uniform blocks: every current pixel c, every reference pixel r, expected sum e
    localparam int NT = 8;
    localparam vec_t TBL [NT] = '{
        '{8'd0,   8'd0,   12'd0},
        '{8'd0,   8'd255, 12'd4080},
        '{8'd255, 8'd0,   12'd4080},
        '{8'd100, 8'd40,  12'd960},
        '{8'd40,  8'd100, 12'd960},
        '{8'd7,   8'd8,   12'd16},
        '{8'd200, 8'd199, 12'd16},
        '{8'd255, 8'd255, 12'd0}
    };

    localparam int NS = 16;
    logic [127:0] s_cur [NS];
    logic [127:0] s_ref [NS];
    logic [11:0]  s_exp [NS];

    function automatic logic [11:0] model_sad(input logic [127:0] c, input logic [127:0] r);
        int acc = 0;
        for (int p = 0; p < 16; p++) begin
            int a = int'(r[p*8 +: 8]);
            int b = int'(c[p*8 +: 8]);
            acc += (a > b) ? a - b : b - a;
        end
        return 12'(acc);
    endfunction

    function automatic logic [127:0] fill(input logic [7:0] v);
        return {16{v}};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] held;

        for (int i = 0; i < NT; i++) begin
            s_cur[i] = fill(TBL[i].c);
            s_ref[i] = fill(TBL[i].r);
            s_exp[i] = TBL[i].e;
        end
        for (int i = NT; i < NS; i++) begin
            for (int p = 0; p < 16; p++) begin
                s_ref[i][p*8 +: 8] = 8'((p * 37 + i * 11) % 256);
                s_cur[i][p*8 +: 8] = 8'((p * 53 + i * 7 + 3) % 256);
            end
            s_exp[i] = model_sad(s_cur[i], s_ref[i]);
        end

        rst = 1'b1; in_valid = 1'b0; cur_pix = '1; ref_pix = '0;
        repeat (3) tick();
        // R4: reset state
        check("R4 out_valid after reset", 32'(out_valid), 0);
        check("R4 sad_out after reset", 32'(sad_out), 0);
        rst = 1'b0;
        tick();

        // R1 R3 R6: back-to-back stream, each result two edges after its input
        for (int k = 0; k < NS + 2; k++) begin
            if (k >= 2) begin
                check("R3 out_valid in stream", 32'(out_valid), 1);
                check("R1 R6 stream sad", 32'(sad_out), 32'(s_exp[k-2]));
            end
            if (k < NS) begin
                in_valid = 1'b1; cur_pix = s_cur[k]; ref_pix = s_ref[k];
            end else begin
                in_valid = 1'b0;
            end
            tick();
        end
        check("R2 out_valid drops after stream", 32'(out_valid), 0);

        // R2: single pulse latency
        in_valid = 1'b1; cur_pix = fill(8'd10); ref_pix = fill(8'd13);
        tick();
        in_valid = 1'b0;
        check("R2 no output after one edge", 32'(out_valid), 0);
        tick();
        check("R2 output after two edges", 32'(out_valid), 1);
        check("R2 pulse sad", 32'(sad_out), 48);
        tick();
        check("R2 single-cycle output pulse", 32'(out_valid), 0);

        // R5: buses change while idle; output holds
        held = sad_out;
        for (int j = 0; j < 4; j++) begin
            cur_pix = fill(8'(j * 60)); ref_pix = fill(8'(255 - j * 17));
            tick();
            check("R5 sad holds while idle", 32'(sad_out), 32'(held));
            check("R5 no valid while idle", 32'(out_valid), 0);
        end

        // R7: pixel pairing by index; matching ramps give 0, one bumped pixel gives its delta
        for (int p = 0; p < 16; p++) begin
            cur_pix[p*8 +: 8] = 8'(p * 16);
            ref_pix[p*8 +: 8] = 8'(p * 16);
        end
        in_valid = 1'b1;
        tick();
        ref_pix[5*8 +: 8] = 8'd83;
        tick();
        in_valid = 1'b0;
        check("R7 matching ramps", 32'(sad_out), 0);
        tick();
        check("R7 pixel 5 delta", 32'(sad_out), 3);

        // R6: swap symmetry on a generated pair
        in_valid = 1'b1; cur_pix = s_ref[NT]; ref_pix = s_cur[NT];
        tick();
        in_valid = 1'b0;
        tick();
        check("R6 swapped operands", 32'(sad_out), 32'(s_exp[NT]));

        // R4: reset in the middle of traffic
        in_valid = 1'b1; cur_pix = fill(8'd0); ref_pix = fill(8'd255);
        tick(); tick();
        check("R4 traffic before reset", 32'(sad_out), 4080);
        rst = 1'b1;
        tick();
        check("R4 mid-stream reset valid", 32'(out_valid), 0);
        check("R4 mid-stream reset sad", 32'(sad_out), 0);
        rst = 1'b0; in_valid = 1'b0;
        tick(); tick();
        check("R4 stale data dropped", 32'(out_valid), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule